// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Converter

This block turns a stream of signed energy samples into a train of fixed-width pulses whose average rate is proportional to the accumulated energy. Each valid sample is scaled by a programmable pulse-rate code and added into a signed accumulator. Whenever the accumulator magnitude reaches one quantum, a pulse is issued and one quantum is removed from the magnitude. A direction pin reports the sign of the accumulated energy.

Pulses may only start in one of four time slots of a repeating frame, chosen by a two-bit phase input. Several converters set to different phases can therefore share one wired line. Both pins can run push-pull or in a pull-down-only mode for wire-AND sharing. An override mode drives the pins directly from two level bits. A sticky flag reports accumulator saturation. An activity flag reports that the pulse train is running.

Top module: `epf_energy_pulse`

## Requirements
- R1: The pulse-rate register counts in units of 1/32 (19 integer bits and 5 fractional bits at the default RATE_W of 24). It resets to code 1024000, which is 32000.0. It loads `rate_in` on any cycle where `rate_ld` is high.
- R2: A rate code of 0 or 1 is treated as code 2, the smallest valid setting (1/16).
- R3: On each cycle with `e_valid` high, `e_sample` × effective rate code is added to a signed ACC_W-bit accumulator. When a pulse starts, the accumulator moves toward zero by the quantum 2^Q_SHIFT.
- R4: A pulse starts only when no pulse is in progress and the accumulator magnitude is at least the quantum, at an opportunity cycle. It then holds `pulse_o` high for exactly PULSE_W cycles.
- R5: Cycles are numbered from 0 starting at the first clock after the internal reset releases. A cycle is an opportunity when its number modulo 4×SLOT_LEN equals `phase_sel`×SLOT_LEN. The pulse rises at the edge that ends that cycle.
- R6: `dir_o` takes the value 1 if the accumulator is negative and 0 otherwise. It is sampled at the edge where a pulse starts and changes at no other time.
- R7: With `wand_en` high, each pin's enable (`pulse_oe`, `dir_oe`) is the inverse of its level, so a pin is driven only while low. With `wand_en` low, both enables are 1.
- R8: With `ovr_en` high, `pulse_o` equals `ovr_lvl[1]` and `dir_o` equals `ovr_lvl[0]` in the same cycle. Accumulation continues underneath.
- R9: A sum that leaves the signed ACC_W range saturates the accumulator and sets `ovf_o`. The flag stays set until `ovf_clr` is high in a cycle with no new saturation; a saturation in the same cycle wins over the clear.
- R10: `active_o` rises together with a pulse start. It falls after an opportunity cycle in which no pulse starts.
- R11: While reset is asserted, `pulse_o`, `dir_o`, `ovf_o` and `active_o` are 0, and with `wand_en` low both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| e_valid | input | 1 | Energy sample strobe |
| e_sample | input | SAMPLE_W | Signed energy sample |
| rate_ld | input | 1 | Load strobe for the pulse-rate register |
| rate_in | input | RATE_W | New pulse-rate code, units of 1/32 |
| phase_sel | input | 2 | Slot of the frame in which pulses may start |
| wand_en | input | 1 | Pull-down-only pin mode |
| ovr_en | input | 1 | Direct pin override enable |
| ovr_lvl | input | 2 | Override levels: bit 1 pulse pin, bit 0 direction pin |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| pulse_o | output | 1 | Pulse pin level |
| pulse_oe | output | 1 | Pulse pin drive enable |
| dir_o | output | 1 | Direction pin level, 1 = negative energy |
| dir_oe | output | 1 | Direction pin drive enable |
| ovf_o | output | 1 | Sticky accumulator saturation flag |
| active_o | output | 1 | Pulse train running flag |

## Verification
The bench builds the block with an 8-bit sample, the full 24-bit rate code, a 32-bit accumulator, a quantum of 2^20, 3-cycle pulses and 5-cycle slots. With these values the reset rate code (1024000) sits just below one quantum per unit sample, so two unit samples yield exactly one pulse and the default rate becomes observable. The 20-cycle frame lets every phase slot be reached within a few dozen cycles. The largest rate code times the largest sample saturates the 32-bit accumulator within two samples, so overflow, the sticky flag and the set-over-clear priority all come within reach.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int RATE_FRAC      = 5;
  localparam int RATE_RESET_INT = 32000;
  localparam int RATE_MIN_CODE  = 2;
  localparam int NUM_PHASES     = 4;
  localparam int PIN_DIR        = 0;
  localparam int PIN_PULSE      = 1;
  localparam int NUM_PINS       = 2;

  typedef struct packed {
    logic neg;
    logic ge_q;
  } acc_stat_t;
endpackage

// File: rtl/epf_phase_timer.sv
module epf_phase_timer #(
  parameter int SLOT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_sel,
  output logic       opp_o
);
  localparam int TW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [TW-1:0] tick_q, tick_d;
  logic [1:0]    slot_q, slot_d;
  logic          tick_last;

  always_comb begin
    tick_last = (tick_q == TW'(SLOT_LEN - 1));
    tick_d    = tick_last ? '0 : tick_q + TW'(1);
    slot_d    = tick_last ? slot_q + 2'd1 : slot_q;
    opp_o     = (tick_q == '0) && (slot_q == phase_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
    end else begin
      tick_q <= tick_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/epf_accum.sv
module epf_accum
  import epf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RATE_W   = 24,
  parameter int ACC_W    = 48,
  parameter int Q_SHIFT  = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rate_ld,
  input  logic [RATE_W-1:0]   rate_in,
  input  logic                e_valid,
  input  logic [SAMPLE_W-1:0] e_sample,
  input  logic                pulse_start,
  input  logic                ovf_clr,
  output acc_stat_t           stat_o,
  output logic                ovf_o
);
  localparam int PROD_W = SAMPLE_W + RATE_W + 1;
  localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;
  localparam logic [RATE_W-1:0] RATE_RST  = RATE_W'(RATE_RESET_INT * (2 ** RATE_FRAC));
  localparam logic [RATE_W-1:0] RATE_MIN  = RATE_W'(RATE_MIN_CODE);
  localparam logic [ACC_W-1:0]  QMAG      = ACC_W'(1) << Q_SHIFT;
  localparam logic signed [SUM_W-1:0] QUANT  = $signed(SUM_W'(1) << Q_SHIFT);
  localparam logic signed [SUM_W-1:0] ACC_HI =
    $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] ACC_LO =
    $signed({{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

  logic [RATE_W-1:0]        rate_q, rate_d, eff_rate;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     ovf_q, ovf_d;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  add_term, drain, sum;
  logic                     sat_hi, sat_lo;
  logic [ACC_W-1:0]         mag;

  assign eff_rate = (rate_q < RATE_MIN) ? RATE_MIN : rate_q;
  assign prod     = $signed(e_sample) * $signed({1'b0, eff_rate});

  always_comb begin
    rate_d   = rate_ld ? rate_in : rate_q;
    add_term = e_valid ? SUM_W'(prod) : '0;
    if (pulse_start) drain = acc_q[ACC_W-1] ? QUANT : -QUANT;
    else             drain = '0;
    sum    = SUM_W'(acc_q) + add_term + drain;
    sat_hi = (sum > ACC_HI);
    sat_lo = (sum < ACC_LO);
    if (sat_hi)      acc_d = ACC_HI[ACC_W-1:0];
    else if (sat_lo) acc_d = ACC_LO[ACC_W-1:0];
    else             acc_d = sum[ACC_W-1:0];
    if (sat_hi || sat_lo) ovf_d = 1'b1;
    else if (ovf_clr)     ovf_d = 1'b0;
    else                  ovf_d = ovf_q;
    mag = acc_q[ACC_W-1] ? (~acc_q + ACC_W'(1)) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      acc_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rate_q <= rate_d;
      acc_q  <= acc_d;
      ovf_q  <= ovf_d;
    end
  end

  assign stat_o.neg  = acc_q[ACC_W-1];
  assign stat_o.ge_q = (mag >= QMAG);
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/epf_pulse_gen.sv
module epf_pulse_gen
  import epf_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      opp,
  input  acc_stat_t stat,
  output logic      start_o,
  output logic      pulse_o,
  output logic      dir_o,
  output logic      active_o
);
  localparam int WW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic          pulse_q, pulse_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          dir_q, dir_d;
  logic          act_q, act_d;
  logic          start;

  always_comb begin
    start   = opp && !pulse_q && stat.ge_q;
    pulse_d = pulse_q;
    wcnt_d  = wcnt_q;
    if (start) begin
      pulse_d = 1'b1;
      wcnt_d  = WW'(PULSE_W - 1);
    end else if (pulse_q) begin
      if (wcnt_q == '0) pulse_d = 1'b0;
      else              wcnt_d  = wcnt_q - WW'(1);
    end
    dir_d = start ? stat.neg : dir_q;
    if (start)    act_d = 1'b1;
    else if (opp) act_d = 1'b0;
    else          act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      wcnt_q  <= '0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      wcnt_q  <= wcnt_d;
      dir_q   <= dir_d;
      act_q   <= act_d;
    end
  end

  assign start_o  = start;
  assign pulse_o  = pulse_q;
  assign dir_o    = dir_q;
  assign active_o = act_q;
endmodule

// File: rtl/epf_pin_drive.sv
module epf_pin_drive
  import epf_pkg::*;
(
  input  logic       pulse_in,
  input  logic       dir_in,
  input  logic       wand_en,
  input  logic       ovr_en,
  input  logic [1:0] ovr_lvl,
  output logic       pulse_o,
  output logic       pulse_oe,
  output logic       dir_o,
  output logic       dir_oe
);
  logic [NUM_PINS-1:0] lvl_int, lvl, oe;

  always_comb begin
    lvl_int            = '0;
    lvl_int[PIN_DIR]   = dir_in;
    lvl_int[PIN_PULSE] = pulse_in;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign lvl[g] = ovr_en ? ovr_lvl[g] : lvl_int[g];
    assign oe[g]  = wand_en ? ~lvl[g] : 1'b1;
  end

  assign pulse_o  = lvl[PIN_PULSE];
  assign pulse_oe = oe[PIN_PULSE];
  assign dir_o    = lvl[PIN_DIR];
  assign dir_oe   = oe[PIN_DIR];
endmodule

// File: rtl/epf_energy_pulse.sv
module epf_energy_pulse
  import epf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RATE_W   = 24,
  parameter int ACC_W    = 48,
  parameter int Q_SHIFT  = 30,
  parameter int PULSE_W  = 4,
  parameter int SLOT_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                e_valid,
  input  logic [SAMPLE_W-1:0] e_sample,
  input  logic                rate_ld,
  input  logic [RATE_W-1:0]   rate_in,
  input  logic [1:0]          phase_sel,
  input  logic                wand_en,
  input  logic                ovr_en,
  input  logic [1:0]          ovr_lvl,
  input  logic                ovf_clr,
  output logic                pulse_o,
  output logic                pulse_oe,
  output logic                dir_o,
  output logic                dir_oe,
  output logic                ovf_o,
  output logic                active_o
);
  logic [1:0] rst_pipe;
  logic       rst_n_i;
  logic       opp;
  logic       pulse_start;
  logic       pulse_raw;
  logic       dir_raw;
  acc_stat_t  acc_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  epf_phase_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .phase_sel (phase_sel),
    .opp_o     (opp)
  );

  epf_accum #(
    .SAMPLE_W (SAMPLE_W),
    .RATE_W   (RATE_W),
    .ACC_W    (ACC_W),
    .Q_SHIFT  (Q_SHIFT)
  ) u_accum (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .rate_ld     (rate_ld),
    .rate_in     (rate_in),
    .e_valid     (e_valid),
    .e_sample    (e_sample),
    .pulse_start (pulse_start),
    .ovf_clr     (ovf_clr),
    .stat_o      (acc_stat),
    .ovf_o       (ovf_o)
  );

  epf_pulse_gen #(.PULSE_W(PULSE_W)) u_pgen (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .opp      (opp),
    .stat     (acc_stat),
    .start_o  (pulse_start),
    .pulse_o  (pulse_raw),
    .dir_o    (dir_raw),
    .active_o (active_o)
  );

  epf_pin_drive u_pins (
    .pulse_in (pulse_raw),
    .dir_in   (dir_raw),
    .wand_en  (wand_en),
    .ovr_en   (ovr_en),
    .ovr_lvl  (ovr_lvl),
    .pulse_o  (pulse_o),
    .pulse_oe (pulse_oe),
    .dir_o    (dir_o),
    .dir_oe   (dir_oe)
  );
endmodule

// File: rtl/epf_energy_pulse_chk.sv
module epf_energy_pulse_chk #(
  parameter int PULSE_W = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_raw,
  input logic       dir_raw,
  input logic       pulse_o,
  input logic       pulse_oe,
  input logic       dir_o,
  input logic       dir_oe,
  input logic       wand_en,
  input logic       ovr_en,
  input logic [1:0] ovr_lvl,
  input logic       ovf_o,
  input logic       ovf_clr,
  input logic       active_o
);
  localparam int CW = $clog2(PULSE_W + 2);

  logic [CW-1:0] hi_cnt_q, hi_cnt_d;

  always_comb hi_cnt_d = pulse_raw ? hi_cnt_q + CW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt_q <= '0;
    else        hi_cnt_q <= hi_cnt_d;
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_raw |-> (hi_cnt_q < CW'(PULSE_W)));

  assert_pulse_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_raw && hi_cnt_q != '0) |-> (hi_cnt_q == CW'(PULSE_W)));

  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pulse_raw) |-> $stable(dir_raw));

  assert_wand_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wand_en |-> (pulse_oe != pulse_o) && (dir_oe != dir_o));

  assert_push_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wand_en |-> (pulse_oe && dir_oe));

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> (pulse_o == ovr_lvl[1]) && (dir_o == ovr_lvl[0]));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr) |=> ovf_o);

  assert_active_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $rose(pulse_raw));
endmodule

bind epf_energy_pulse epf_energy_pulse_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pulse_raw (pulse_raw),
  .dir_raw   (dir_raw),
  .pulse_o   (pulse_o),
  .pulse_oe  (pulse_oe),
  .dir_o     (dir_o),
  .dir_oe    (dir_oe),
  .wand_en   (wand_en),
  .ovr_en    (ovr_en),
  .ovr_lvl   (ovr_lvl),
  .ovf_o     (ovf_o),
  .ovf_clr   (ovf_clr),
  .active_o  (active_o)
);

// File: tb/epf_energy_pulse_tb_top.sv
`timescale 1ns/1ps
module epf_energy_pulse_tb_top;
  localparam int SAMPLE_W = 8;
  localparam int RATE_W   = 24;
  localparam int ACC_W    = 32;
  localparam int Q_SHIFT  = 20;
  localparam int PULSE_W  = 3;
  localparam int SLOT_LEN = 5;
  localparam int FRAME    = 4 * SLOT_LEN;
  localparam longint QV     = 64'sd1 <<< Q_SHIFT;
  localparam longint ACC_MX = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint ACC_MN = -(64'sd1 <<< (ACC_W - 1));

  logic                       clk = 1'b0;
  logic                       rst_n;
  logic                       e_valid;
  logic signed [SAMPLE_W-1:0] e_sample;
  logic                       rate_ld;
  logic [RATE_W-1:0]          rate_in;
  logic [1:0]                 phase_sel;
  logic                       wand_en, ovr_en, ovf_clr;
  logic [1:0]                 ovr_lvl;
  logic pulse_o, pulse_oe, dir_o, dir_oe, ovf_o, active_o;

  always #5 clk = ~clk;

  epf_energy_pulse #(
    .SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W), .ACC_W(ACC_W),
    .Q_SHIFT(Q_SHIFT), .PULSE_W(PULSE_W), .SLOT_LEN(SLOT_LEN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .e_valid(e_valid), .e_sample(e_sample),
    .rate_ld(rate_ld), .rate_in(rate_in), .phase_sel(phase_sel),
    .wand_en(wand_en), .ovr_en(ovr_en), .ovr_lvl(ovr_lvl), .ovf_clr(ovf_clr),
    .pulse_o(pulse_o), .pulse_oe(pulse_oe), .dir_o(dir_o), .dir_oe(dir_oe),
    .ovf_o(ovf_o), .active_o(active_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int pcount = 0;
  bit finished = 0;

  // Behavioural reference state
  longint m_acc, m_rate, mcyc;
  int     m_tick, m_slot, m_wl, m_last_phase;
  bit     m_pulse, m_dir, m_act, m_ovf;
  bit [1:0] m_rs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_rate = 32000 * 32; mcyc = 0;
      m_tick = 0; m_slot = 0; m_wl = 0; m_last_phase = 0;
      m_pulse = 0; m_dir = 0; m_act = 0; m_ovf = 0; m_rs = 2'b00;
    end else begin
      if (m_rs[1]) begin
        bit opp, st;
        longint mag, effr, add, drain, sum;
        opp  = (m_tick == 0) && (m_slot == int'(phase_sel));
        mag  = (m_acc < 0) ? -m_acc : m_acc;
        st   = opp && !m_pulse && (mag >= QV);
        effr = (m_rate < 2) ? 2 : m_rate;
        add  = e_valid ? longint'(e_sample) * effr : 0;
        drain = st ? ((m_acc < 0) ? QV : -QV) : 0;
        sum  = m_acc + add + drain;
        if (st) m_dir = (m_acc < 0);
        if (st) begin m_pulse = 1; m_wl = PULSE_W - 1; end
        else if (m_pulse) begin
          if (m_wl == 0) m_pulse = 0; else m_wl = m_wl - 1;
        end
        if (st) m_act = 1; else if (opp) m_act = 0;
        if (sum > ACC_MX) begin m_acc = ACC_MX; m_ovf = 1; end
        else if (sum < ACC_MN) begin m_acc = ACC_MN; m_ovf = 1; end
        else begin m_acc = sum; if (ovf_clr) m_ovf = 0; end
        if (rate_ld) m_rate = longint'(rate_in);
        if (m_tick == SLOT_LEN - 1) begin m_tick = 0; m_slot = (m_slot + 1) % 4; end
        else m_tick = m_tick + 1;
        m_last_phase = int'(phase_sel);
        mcyc = mcyc + 1;
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_val(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  bit prev_pulse = 0;
  bit prev_ovr   = 0;
  always begin
    @(negedge clk);
    #1;
    begin
      bit ep, ed;
      ep = ovr_en ? ovr_lvl[1] : m_pulse;
      ed = ovr_en ? ovr_lvl[0] : m_dir;
      cmp(ovr_en ? "R8 pulse pin" : "R4 pulse pin", pulse_o, ep);
      cmp(ovr_en ? "R8 dir pin" : "R6 dir pin", dir_o, ed);
      cmp("R7 pulse enable", pulse_oe, wand_en ? !ep : 1'b1);
      cmp("R7 dir enable", dir_oe, wand_en ? !ed : 1'b1);
      cmp("R9 overflow flag", ovf_o, m_ovf);
      cmp("R10 active flag", active_o, m_act);
      if (!ovr_en && !prev_ovr && pulse_o && !prev_pulse) begin
        pcount++;
        check_val("R5 pulse slot", (mcyc - 1) % FRAME, longint'(m_last_phase * SLOT_LEN));
      end
      prev_pulse = pulse_o;
      prev_ovr   = ovr_en;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed(int s);
    @(negedge clk);
    e_valid = 1'b1; e_sample = SAMPLE_W'(s);
    @(negedge clk);
    e_valid = 1'b0;
  endtask

  task automatic load_rate(longint r);
    @(negedge clk);
    rate_ld = 1'b1; rate_in = RATE_W'(r);
    @(negedge clk);
    rate_ld = 1'b0;
  endtask

  task automatic check_reset_state();
    #2;
    check_val("R11 pulse_o in reset", pulse_o, 0);
    check_val("R11 dir_o in reset", dir_o, 0);
    check_val("R11 ovf_o in reset", ovf_o, 0);
    check_val("R11 active_o in reset", active_o, 0);
    check_val("R11 enables in reset", {pulse_oe, dir_oe}, 3);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; e_valid = 0; e_sample = '0; rate_ld = 0; rate_in = '0;
    phase_sel = 2'd0; wand_en = 0; ovr_en = 0; ovr_lvl = 2'b00; ovf_clr = 0;
    wait_cyc(3);
    check_reset_state();
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);

    // R1: default rate 1024000 per unit sample, quantum 1048576
    feed(1);
    wait_cyc(60);
    check_val("R1 one unit sample below quantum", pcount, 0);
    feed(1);
    wait_cyc(60);
    check_val("R1 two unit samples give one pulse", pcount, 1);

    // R3: rate 32768, +96 -> three quanta added
    base = pcount;
    load_rate(32768);
    feed(96);
    wait_cyc(100);
    check_val("R3 pulse count for positive energy", pcount - base, 3);

    // R6: negative energy drives direction high
    base = pcount;
    feed(-100);
    wait_cyc(80);
    check_val("R3 pulse count for negative energy", pcount - base, 2);
    #2 check_val("R6 direction negative", dir_o, 1);

    // R5: other phases
    base = pcount;
    @(negedge clk) phase_sel = 2'd2;
    feed(64);
    wait_cyc(60);
    check_val("R5 pulse in phase 2", pcount - base, 1);
    #2 check_val("R6 direction positive", dir_o, 0);
    base = pcount;
    @(negedge clk) phase_sel = 2'd3;
    feed(40);
    wait_cyc(80);
    check_val("R5 pulses in phase 3", pcount - base, 2);
    #2 check_val("R10 active cleared when idle", active_o, 0);

    // R7: wire-AND pin mode while pulsing
    @(negedge clk) begin wand_en = 1'b1; phase_sel = 2'd1; end
    feed(64);
    wait_cyc(60);
    #2 check_val("R7 low pin is driven", pulse_oe, !pulse_o);
    @(negedge clk) wand_en = 1'b0;

    // R8: override, accumulation continues underneath
    @(negedge clk) begin ovr_en = 1'b1; ovr_lvl = 2'b10; end
    #2 check_val("R8 override pulse high dir low", {pulse_o, dir_o}, 2);
    feed(-64);
    @(negedge clk) ovr_lvl = 2'b01;
    #2 check_val("R8 override pulse low dir high", {pulse_o, dir_o}, 1);
    wait_cyc(60);
    @(negedge clk) ovr_en = 1'b0;
    wait_cyc(40);

    // R9: saturation, stickiness, clear, set-over-clear
    load_rate(64'hFF_FFFF);
    feed(127);
    feed(127);
    wait_cyc(2);
    #2 check_val("R9 overflow set", ovf_o, 1);
    wait_cyc(40);
    #2 check_val("R9 overflow sticky", ovf_o, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    wait_cyc(1);
    #2 check_val("R9 overflow cleared", ovf_o, 0);
    @(negedge clk) begin ovf_clr = 1'b1; e_valid = 1'b1; e_sample = 8'sd127; end
    @(negedge clk) begin ovf_clr = 1'b0; e_valid = 1'b0; end
    wait_cyc(1);
    #2 check_val("R9 saturation wins over clear", ovf_o, 1);

    // R11: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    check_reset_state();
    wait_cyc(2);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);

    // R2: rate code 1 acts as code 2; 4200 x 127 x 2 = 1066800 -> one pulse
    base = pcount;
    load_rate(1);
    @(negedge clk) begin e_valid = 1'b1; e_sample = 8'sd127; end
    wait_cyc(4200);
    @(negedge clk) e_valid = 1'b0;
    wait_cyc(60);
    check_val("R2 minimum rate clamp", pcount - base, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule